// File: doc/BRIEF.md
# Sector Result Status Byte

This block turns the outcome of one sector read attempt into an 8-bit status byte. The command sequencer and the disk front end already know several things about the attempt: the kind of read that was requested (ordinary data or deleted data), whether a data address mark was found, and which kind it was. They also know whether the data field failed its CRC, the track number read from the sector ID, and the track number the controller believes the head is on. This block does not detect marks, compute CRCs or sequence commands. It only classifies the facts it is handed.

A command begins with a start strobe, which clears the byte. When the attempt ends, the sequencer raises a done strobe for one cycle. The classified flags are captured on that edge and appear on the output in the following cycle. They then stay unchanged until the next start, so software or the result phase can read the byte at leisure. The bit positions are fixed because the result-phase logic decodes them.

Top module: `sector_result_status`

## Requirements
- R1: While and after reset, with no command run, the status byte reads 0x00.
- R2: A start strobe clears the status byte to 0x00 on the next cycle. If start and done are high in the same cycle, start wins and the byte becomes 0x00.
- R3: Without a done strobe, the status byte holds its value whatever the other inputs do.
- R4: Bit 6 (control-mark) is set when a mark was found and its kind disagrees with the command: an ordinary read (cmd_deleted=0) meets a deleted mark (mark_deleted=1), or a deleted read (cmd_deleted=1) meets an ordinary mark (mark_deleted=0).
- R5: Bit 5 (data error) is set when crc_err is high and a mark was found.
- R6: Bit 4 (wrong track) is set when id_track differs from cur_track.
- R7: Bit 1 (bad track) is set only when id_track differs from cur_track and id_track is all ones (0xFF at the default width). It is clear when both are 0xFF.
- R8: Bit 0 (missing mark) is set when mark_found=0. In that case bits 6 and 5 are forced to 0.
- R9: Bits 7, 3 and 2 always read 0.
- R10: The flags sampled on a done edge appear on status in the cycle after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start of a new command; clears the byte |
| cmd_done | input | 1 | End of the read attempt; captures the flags |
| cmd_deleted | input | 1 | 1 = read-deleted-data command, 0 = ordinary read |
| mark_found | input | 1 | 1 = a data address mark was detected |
| mark_deleted | input | 1 | Kind of mark found: 1 = deleted, 0 = ordinary |
| crc_err | input | 1 | CRC error in the data field |
| id_track | input | TRACK_W | Track number read from the sector ID field |
| cur_track | input | TRACK_W | Track number held by the controller |
| status | output | 8 | Result status byte |

## Verification
The bound checker watches the structural rules on every cycle:
- the reserved bits are always zero;
- missing-mark masks the control-mark and data-error bits;
- bad track never appears without wrong track;
- a start always clears the byte;
- the byte never moves without a done;
- the track and missing-mark bits follow the inputs sampled at the done edge.

The scoreboard covers what the checker does not:
- every pairing of command kind and mark kind, with and without CRC errors;
- track values that are equal, unequal, 0xFF on the ID only, and 0xFF on both sides;
- the one-cycle latency of the capture;
- the priority of start over done when both arrive together.

// File: rtl/srs_pkg.sv
package srs_pkg;

  localparam int unsigned STAT_W = 8;

  // Bit positions decoded by the result-phase logic
  localparam int unsigned B_CTL  = 6;
  localparam int unsigned B_DERR = 5;
  localparam int unsigned B_WTRK = 4;
  localparam int unsigned B_BTRK = 1;
  localparam int unsigned B_MISS = 0;

  typedef struct packed {
    logic ctl;
    logic derr;
    logic wtrk;
    logic btrk;
    logic miss;
  } flags_t;

  localparam flags_t FLAGS_CLEAR = '{ctl: 1'b0, derr: 1'b0, wtrk: 1'b0, btrk: 1'b0, miss: 1'b0};

  // Mark kind disagrees with command kind
  function automatic logic kind_conflict(input logic want_deleted, input logic got_deleted);
    return want_deleted ^ got_deleted;
  endfunction

  // Lay the flags out on the status byte; unused bits stay zero
  function automatic logic [STAT_W-1:0] pack_status(input flags_t f);
    logic [STAT_W-1:0] b;
    b         = '0;
    b[B_CTL]  = f.ctl;
    b[B_DERR] = f.derr;
    b[B_WTRK] = f.wtrk;
    b[B_BTRK] = f.btrk;
    b[B_MISS] = f.miss;
    return b;
  endfunction

endpackage

// File: rtl/srs_classify.sv
module srs_classify
  import srs_pkg::*;
#(
  parameter int unsigned TRACK_W = 8
) (
  input  logic               cmd_deleted,
  input  logic               mark_found,
  input  logic               mark_deleted,
  input  logic               crc_err,
  input  logic [TRACK_W-1:0] id_track,
  input  logic [TRACK_W-1:0] cur_track,
  output flags_t             flags
);

  localparam logic [TRACK_W-1:0] BAD_TRACK = {TRACK_W{1'b1}};

  logic trk_differs;
  logic id_is_bad;
  logic mark_conflict;

  assign trk_differs   = (id_track != cur_track);
  assign id_is_bad     = (id_track == BAD_TRACK);
  assign mark_conflict = kind_conflict(cmd_deleted, mark_deleted);

  always_comb begin
    flags      = FLAGS_CLEAR;
    flags.miss = ~mark_found;
    flags.wtrk = trk_differs;
    flags.btrk = trk_differs & id_is_bad;
    // Without a data field there is nothing to judge
    flags.ctl  = mark_found & mark_conflict;
    flags.derr = mark_found & crc_err;
  end

endmodule

// File: rtl/srs_hold.sv
module srs_hold
  import srs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  flags_t            flags_in,
  output logic [STAT_W-1:0] status
);

  flags_t held;

  always_ff @(posedge clk) begin
    if (!rst_n)       held <= FLAGS_CLEAR;
    else if (clear)   held <= FLAGS_CLEAR;
    else if (capture) held <= flags_in;
  end

  assign status = pack_status(held);

endmodule

// File: rtl/sector_result_status.sv
module sector_result_status
  import srs_pkg::*;
#(
  parameter int unsigned TRACK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_start,
  input  logic               cmd_done,
  input  logic               cmd_deleted,
  input  logic               mark_found,
  input  logic               mark_deleted,
  input  logic               crc_err,
  input  logic [TRACK_W-1:0] id_track,
  input  logic [TRACK_W-1:0] cur_track,
  output logic [7:0]         status
);

  flags_t next_flags;
  logic   capture_evt;
  logic   clear_evt;

  // Start takes precedence over done
  assign clear_evt   = cmd_start;
  assign capture_evt = cmd_done & ~cmd_start;

  srs_classify #(.TRACK_W(TRACK_W)) u_classify (
    .cmd_deleted (cmd_deleted),
    .mark_found  (mark_found),
    .mark_deleted(mark_deleted),
    .crc_err     (crc_err),
    .id_track    (id_track),
    .cur_track   (cur_track),
    .flags       (next_flags)
  );

  srs_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear_evt),
    .capture (capture_evt),
    .flags_in(next_flags),
    .status  (status)
  );

endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
  parameter int unsigned TRACK_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_start,
  input logic               cmd_done,
  input logic               mark_found,
  input logic [TRACK_W-1:0] id_track,
  input logic [TRACK_W-1:0] cur_track,
  input logic [7:0]         status
);

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] == 1'b0) && (status[3] == 1'b0) && (status[2] == 1'b0));

  // R8
  missing_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (status[6] == 1'b0) && (status[5] == 1'b0));

  // R7
  bad_needs_wrong_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> status[4]);

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (status == 8'h00));

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_start && !cmd_done) |=> $stable(status));

  // R6
  wrong_track_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !cmd_start) |=> (status[4] == $past(id_track != cur_track)));

  // R8
  missing_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !cmd_start) |=> (status[0] == !$past(mark_found)));

endmodule

bind sector_result_status srs_chk #(.TRACK_W(TRACK_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_start(cmd_start),
  .cmd_done (cmd_done),
  .mark_found(mark_found),
  .id_track (id_track),
  .cur_track(cur_track),
  .status   (status)
);

// File: tb/sector_result_status_bench.sv
module sector_result_status_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_start = 1'b0, cmd_done = 1'b0;
  logic       cmd_deleted = 1'b0, mark_found = 1'b0, mark_deleted = 1'b0, crc_err = 1'b0;
  logic [7:0] id_track = 8'h00, cur_track = 8'h00;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] tags_q[$];

  always #10 clk = ~clk;  // 50 MHz

  sector_result_status u_sector_result_status (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_done(cmd_done),
    .cmd_deleted(cmd_deleted), .mark_found(mark_found), .mark_deleted(mark_deleted),
    .crc_err(crc_err), .id_track(id_track), .cur_track(cur_track), .status(status)
  );

  // Independent model of the byte, from the requirements
  function automatic logic [7:0] model(input logic rd_del, input logic fnd, input logic mk_del,
                                       input logic crc, input logic [7:0] idt, input logic [7:0] cur);
    logic [7:0] r;
    r = 8'h00;
    if (!fnd) r = r | 8'h01;                              // R8
    else begin
      if (rd_del != mk_del) r = r | 8'h40;                // R4
      if (crc)              r = r | 8'h20;                // R5
    end
    if (idt != cur) begin
      r = r | 8'h10;                                      // R6
      if (idt == 8'hFF) r = r | 8'h02;                    // R7
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: status=%02h expected=%02h", req, got, exp);
    end
  endtask

  // Driver: one complete command
  task automatic run_cmd(input logic rd_del, input logic fnd, input logic mk_del,
                         input logic crc, input logic [7:0] idt, input logic [7:0] cur);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    check("R2", status, 8'h00);
    cmd_deleted = rd_del; mark_found = fnd; mark_deleted = mk_del;
    crc_err = crc; id_track = idt; cur_track = cur;
    cmd_done = 1'b1;
    exp_q.push_back(model(rd_del, fnd, mk_del, crc, idt, cur));
    check("R10", status, 8'h00);  // not yet visible before the edge
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  // Monitor: compares each captured result
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && cmd_done && !cmd_start) begin
        @(negedge clk);
        if (exp_q.size() > 0) check("R4/R5/R6/R7/R8/R9/R10", status, exp_q.pop_front());
        else begin
          checks++; errors++;
          $display("FAIL R10: unexpected capture, status=%02h expected=none", status);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: status=%02h expected=finish", status);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check("R1", status, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", status, 8'h00);

    for (int c = 0; c < 2; c++)
      for (int m = 0; m < 3; m++)
        for (int e = 0; e < 2; e++)
          for (int t = 0; t < 4; t++) begin
            logic [7:0] a, b;
            case (t)
              0: begin a = 8'h12; b = 8'h12; end
              1: begin a = 8'h13; b = 8'h27; end
              2: begin a = 8'hFF; b = 8'h05; end
              default: begin a = 8'hFF; b = 8'hFF; end
            endcase
            run_cmd(c[0], m != 0, m == 2, e[0], a, b);
          end

    // R3: inputs wander without done; byte must not move
    run_cmd(1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h01);
    held = status;
    check("R3", held, 8'hF2 & 8'h73);
    for (int k = 0; k < 6; k++) begin
      cmd_deleted = k[0]; mark_found = k[1]; mark_deleted = k[2];
      crc_err = ~k[0]; id_track = 8'(k * 37); cur_track = 8'(k);
      @(negedge clk);
      check("R3", status, held);
    end

    // R2: start and done together -> clear wins
    cmd_start = 1'b1; cmd_done = 1'b1;
    mark_found = 1'b0; id_track = 8'hFF; cur_track = 8'h00;
    @(negedge clk);
    cmd_start = 1'b0; cmd_done = 1'b0;
    check("R2", status, 8'h00);
    @(negedge clk);
    check("R2", status, 8'h00);

    @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10: %0d results never seen, status=%02h expected=empty", exp_q.size(), status);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule